// File: doc/BRIEF.md
# Dual-Slope Converter Sequencer

This block is the digital control for a fully differential double-integration analog-to-digital converter. The integrator, the voltage-to-current stage and the two comparators sit outside the block. The block drives them through a multiplexer select code. It reads the two comparator decisions through a two-flop synchronizer. It turns the timing of a comparator crossing into an (n+1)-bit signed-magnitude result.

A frame starts on a start request from idle. First, a reset pulse clears residual integrator charge. Next the sampled input is integrated for a fixed window of 2^n cycles, and the input sign is taken from the comparators during that window. A reference of opposite polarity is then applied. The counter opens after a programmable latency allowance and counts until the comparator reports the crossing. After the crossing, zero is applied for the rest of the window. The magnitude and sign are published with a one-cycle valid strobe. A short run-down makes the next reset pulse use the lowered amplitude.

Top module: `dsadc_ctrl`

## Requirements
- R1: While rst_ni is low, and right after it is released, mux_sel_o is 0 (zero), cnt_en_o is 0, valid_o is 0, result_o is 0 and amp_low_o is 0.
- R2: From idle, a frame begins only on start_i. A start_i pulse during a running frame does not lengthen or repeat the frame. After valid_o the block stays idle, with mux_sel_o = 0 and cnt_en_o = 0.
- R3: mux_sel_o codes are 0 zero, 1 sample, 2 positive reference, 3 negative reference and 4 reset pulse. A frame shows code 4 for exactly T_DEL cycles, then code 1 for exactly 2^N_BITS cycles, then a reference code.
- R4: If cmp_pos_i is high during the sample window, the reference code is 3. Otherwise it is 2. The code stays fixed while counting runs.
- R5: Counting opens T_LAT cycles after the reference is first applied, and cnt_en_o is high only while a reference code is on mux_sel_o. With T_LAT = 2, suppose the active comparator (cmp_pos_i for a positive input, cmp_neg_i otherwise) falls D cycles after the reference is first applied, with D < 2^N_BITS. Then the magnitude is D and cnt_en_o is high for D+1 cycles.
- R6: After the crossing is seen, mux_sel_o returns to 0 for the remainder of the window. A reference code is shown for min(D+3, 2^N_BITS+2) cycles in total.
- R7: If no crossing occurs within the window, the magnitude saturates at all ones.
- R8: result_o bit N_BITS holds the sign (1 = positive) and bits N_BITS-1:0 hold the magnitude. valid_o is high for one cycle per frame, and result_o changes only in a valid_o cycle.
- R9: valid_o rises T_DEL + 2*2^N_BITS + T_LAT + 2 cycles after the cycle in which start_i was sampled.
- R10: amp_low_o is high only during the reset pulse. It is high there only when the previous frame's magnitude was below T_LOW (not after reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request, sampled in idle |
| cmp_pos_i | input | 1 | Positive-path comparator decision (asynchronous) |
| cmp_neg_i | input | 1 | Negative-path comparator decision (asynchronous) |
| mux_sel_o | output | 3 | Analog multiplexer select code |
| amp_low_o | output | 1 | Lowered reset-pulse amplitude select |
| cnt_en_o | output | 1 | Counter clock gate enable |
| result_o | output | N_BITS+1 | Sign and magnitude of the last conversion |
| valid_o | output | 1 | One-cycle result strobe |

## Verification
A wrong phase timer shows up at once in the number of cycles each select code is held, and in the cycle in which valid_o rises. These are checked against exact counts in every frame. A wrong sign capture shows on the reference code, which appears a few cycles after the sample window. A counter or synchronizer fault shifts the magnitude and the cnt_en_o length by whole cycles, and this is seen at the end of the same frame. A stale small-input flag shows only in the next frame's reset pulse, so frames with short and long run-downs are chained back to back.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;
  typedef enum logic [2:0] {
    MUX_ZERO      = 3'd0,
    MUX_SAMPLE    = 3'd1,
    MUX_REF_POS   = 3'd2,
    MUX_REF_NEG   = 3'd3,
    MUX_RST_PULSE = 3'd4
  } mux_sel_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RSTP,
    PH_INTEG,
    PH_LAT,
    PH_RUNDN,
    PH_DONE
  } phase_e;
endpackage

// File: rtl/dsadc_sync.sv
module dsadc_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= '0;
        else         stg_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= '0;
        else         stg_q <= {stg_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dsadc_mag.sv
module dsadc_mag #(
  parameter int N_BITS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic              hit_i,
  output logic [N_BITS-1:0] cnt_o,
  output logic              stop_o
);
  localparam logic [N_BITS-1:0] CNT_MAX = '1;

  logic [N_BITS-1:0] cnt_q;
  logic              stop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      stop_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      stop_q <= 1'b0;
    end else if (en_i && !stop_q) begin
      if (hit_i)                stop_q <= 1'b1;
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign stop_o = stop_q;
endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq
  import dsadc_pkg::*;
#(
  parameter int N_BITS = 4,
  parameter int T_LAT  = 2,
  parameter int T_DEL  = 2,
  parameter int T_LOW  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              cmp_pos_i,
  input  logic              cmp_neg_i,
  input  logic [N_BITS-1:0] cnt_i,
  input  logic              stop_i,
  output logic              clr_o,
  output logic              run_o,
  output logic              hit_o,
  output logic              done_o,
  output logic              sign_o,
  output logic              amp_low_o,
  output mux_sel_e          mux_sel_o
);
  localparam int WIN  = 2 ** N_BITS;
  localparam int TM1  = (T_DEL > T_LAT) ? T_DEL : T_LAT;
  localparam int TMAX = (WIN > TM1) ? WIN : TM1;
  localparam int TW   = $clog2(TMAX + 1);

  phase_e        ph_q, ph_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          sign_q, low_q;
  logic          tmr_end;

  assign tmr_end = (tmr_q == '0);

  always_comb begin
    ph_d  = ph_q;
    tmr_d = tmr_end ? tmr_q : tmr_q - TW'(1);
    unique case (ph_q)
      PH_IDLE:  if (start_i) begin ph_d = PH_RSTP;  tmr_d = TW'(T_DEL - 1); end
      PH_RSTP:  if (tmr_end) begin ph_d = PH_INTEG; tmr_d = TW'(WIN - 1);   end
      PH_INTEG: if (tmr_end) begin ph_d = PH_LAT;   tmr_d = TW'(T_LAT - 1); end
      PH_LAT:   if (tmr_end) begin ph_d = PH_RUNDN; tmr_d = TW'(WIN - 1);   end
      PH_RUNDN: if (tmr_end) ph_d = PH_DONE;
      PH_DONE:  ph_d = PH_IDLE;
      default:  ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      tmr_q  <= '0;
      sign_q <= 1'b0;
      low_q  <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      tmr_q <= tmr_d;
      if (ph_q == PH_INTEG) sign_q <= cmp_pos_i;
      if (ph_q == PH_DONE)  low_q  <= (int'(cnt_i) < T_LOW);
    end
  end

  // crossing: the comparator on the input's own side has dropped
  assign hit_o     = sign_q ? !cmp_pos_i : !cmp_neg_i;
  assign clr_o     = (ph_q == PH_INTEG);
  assign run_o     = (ph_q == PH_RUNDN);
  assign done_o    = (ph_q == PH_DONE);
  assign sign_o    = sign_q;
  assign amp_low_o = low_q && (ph_q == PH_RSTP);

  always_comb begin
    unique case (ph_q)
      PH_RSTP:  mux_sel_o = MUX_RST_PULSE;
      PH_INTEG: mux_sel_o = MUX_SAMPLE;
      PH_LAT:   mux_sel_o = sign_q ? MUX_REF_NEG : MUX_REF_POS;
      PH_RUNDN: mux_sel_o = stop_i ? MUX_ZERO : (sign_q ? MUX_REF_NEG : MUX_REF_POS);
      default:  mux_sel_o = MUX_ZERO;
    endcase
  end
endmodule

// File: rtl/dsadc_ctrl.sv
module dsadc_ctrl
  import dsadc_pkg::*;
#(
  parameter int N_BITS = 4,
  parameter int T_LAT  = 2,
  parameter int T_DEL  = 2,
  parameter int T_LOW  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              cmp_pos_i,
  input  logic              cmp_neg_i,
  output logic [2:0]        mux_sel_o,
  output logic              amp_low_o,
  output logic              cnt_en_o,
  output logic [N_BITS:0]   result_o,
  output logic              valid_o
);
  logic [1:0]        cmp_s;
  logic [N_BITS-1:0] cnt;
  logic              stop, clr, run, hit, done, sign;
  mux_sel_e          mux_sel;
  logic [N_BITS:0]   result_q;
  logic              valid_q;

  dsadc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cmp_pos_i, cmp_neg_i}),
    .q_o    (cmp_s)
  );

  dsadc_seq #(.N_BITS(N_BITS), .T_LAT(T_LAT), .T_DEL(T_DEL), .T_LOW(T_LOW)) i_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .cmp_pos_i (cmp_s[1]),
    .cmp_neg_i (cmp_s[0]),
    .cnt_i     (cnt),
    .stop_i    (stop),
    .clr_o     (clr),
    .run_o     (run),
    .hit_o     (hit),
    .done_o    (done),
    .sign_o    (sign),
    .amp_low_o (amp_low_o),
    .mux_sel_o (mux_sel)
  );

  dsadc_mag #(.N_BITS(N_BITS)) i_mag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .en_i   (run),
    .hit_i  (hit),
    .cnt_o  (cnt),
    .stop_o (stop)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= done;
      if (done) result_q <= {sign, cnt};
    end
  end

  assign mux_sel_o = mux_sel;
  assign cnt_en_o  = run && !stop;
  assign result_o  = result_q;
  assign valid_o   = valid_q;
endmodule

// File: rtl/dsadc_ctrl_chk.sv
module dsadc_ctrl_chk #(
  parameter int N_BITS = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [2:0]      mux_sel_i,
  input logic            amp_low_i,
  input logic            cnt_en_i,
  input logic [N_BITS:0] result_i,
  input logic            valid_i
);
  // R8
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> !valid_i);

  // R8
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> $stable(result_i));

  // R5
  cnt_gate_ref_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_en_i |-> (mux_sel_i == 3'd2 || mux_sel_i == 3'd3));

  // R10
  amp_low_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    amp_low_i |-> (mux_sel_i == 3'd4));

  // R3
  sample_after_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mux_sel_i == 3'd1 && $past(mux_sel_i) != 3'd1) |-> ($past(mux_sel_i) == 3'd4));

  // R4
  ref_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i && $past(cnt_en_i)) |-> $stable(mux_sel_i));
endmodule

bind dsadc_ctrl dsadc_ctrl_chk #(.N_BITS(N_BITS)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mux_sel_i (mux_sel_o),
  .amp_low_i (amp_low_o),
  .cnt_en_i  (cnt_en_o),
  .result_i  (result_o),
  .valid_i   (valid_o)
);

// File: tb/test_dsadc_ctrl.sv
`timescale 1ns/1ps
module test_dsadc_ctrl;
  localparam int N_BITS = 4;
  localparam int T_LAT  = 2;
  localparam int T_DEL  = 2;
  localparam int T_LOW  = 2;
  localparam int WIN    = 2 ** N_BITS;
  localparam int FRAME  = T_DEL + 2 * WIN + T_LAT + 2;

  localparam int NV = 9;
  localparam int V_POS [NV] = '{1, 0, 1, 0, 1, 1, 0, 0, 1};
  localparam int V_D   [NV] = '{5, 5, 0, 0, 15, 20, 20, 1, 9};
  localparam int V_EXP [NV] = '{21, 5, 16, 0, 31, 31, 15, 1, 25};
  localparam int V_MID [NV] = '{0, 1, 0, 0, 0, 0, 0, 0, 0};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic cmp_pos_i = 1'b0;
  logic cmp_neg_i = 1'b0;
  logic [2:0] mux_sel_o;
  logic amp_low_o, cnt_en_o, valid_o;
  logic [N_BITS:0] result_o;

  int n_chk = 0;
  int n_fail = 0;
  int prev_small = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dsadc_ctrl #(.N_BITS(N_BITS), .T_LAT(T_LAT), .T_DEL(T_DEL), .T_LOW(T_LOW)) i_dsadc_ctrl (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .cmp_pos_i (cmp_pos_i),
    .cmp_neg_i (cmp_neg_i),
    .mux_sel_o (mux_sel_o),
    .amp_low_o (amp_low_o),
    .cnt_en_o  (cnt_en_o),
    .result_o  (result_o),
    .valid_o   (valid_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk({req, " mux"}, int'(mux_sel_o), 0);
    chk({req, " cnt_en"}, int'(cnt_en_o), 0);
    chk({req, " valid"}, int'(valid_o), 0);
    chk({req, " amp_low"}, int'(amp_low_o), 0);
  endtask

  task automatic run_frame(input int pos, input int d, input int exp_res, input int mid);
    int k, n_rst, n_samp, n_ref, n_en, first_ref, amp_seen, amp_bad, got, res, mag;
    k = 0; n_rst = 0; n_samp = 0; n_ref = 0; n_en = 0; first_ref = -1;
    amp_seen = 0; amp_bad = 0; got = 0; res = 0;
    mag = (d > WIN - 1) ? WIN - 1 : d;
    @(negedge clk);
    cmp_pos_i = (pos != 0);
    cmp_neg_i = (pos == 0);
    start_i = 1'b1;
    while (got == 0 && k < 4 * FRAME) begin
      @(negedge clk);
      k++;
      start_i = (mid != 0 && k == 9);
      if (mux_sel_o == 3'd4) begin
        n_rst++;
        if (amp_low_o) amp_seen = 1;
      end else if (amp_low_o) amp_bad = 1;
      if (mux_sel_o == 3'd1) n_samp++;
      if (mux_sel_o == 3'd2 || mux_sel_o == 3'd3) begin
        if (first_ref < 0) first_ref = int'(mux_sel_o);
        n_ref++;
      end
      if (cnt_en_o) n_en++;
      cmp_pos_i = (pos != 0) && !(n_ref > d);
      cmp_neg_i = (pos == 0) && !(n_ref > d);
      if (valid_o) begin
        got = 1;
        res = int'(result_o);
      end
    end
    chk("R9 valid latency", k, FRAME);
    chk("R8/R5/R7 result", res, exp_res);
    chk("R3 reset pulse length", n_rst, T_DEL);
    chk("R3 sample length", n_samp, WIN);
    chk("R4 reference code", first_ref, (pos != 0) ? 3 : 2);
    chk("R6 reference cycles", n_ref, (d + 3 < WIN + 2) ? d + 3 : WIN + 2);
    chk("R5 gate cycles", n_en, (d + 1 < WIN) ? d + 1 : WIN);
    chk("R10 lowered amplitude", amp_seen, prev_small);
    chk("R10 amplitude outside pulse", amp_bad, 0);
    @(negedge clk);
    chk("R8 valid one cycle", int'(valid_o), 0);
    chk("R8 result held", int'(result_o), exp_res);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R2 idle after frame mux", int'(mux_sel_o), 0);
      chk("R2 idle after frame gate", int'(cnt_en_o), 0);
    end
    prev_small = (mag < T_LOW) ? 1 : 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_idle("R1 in reset");
    chk("R1 result in reset", int'(result_o), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk_idle("R1 after reset");
    chk("R2 no start stays idle", int'(mux_sel_o), 0);

    for (int v = 0; v < NV; v++) run_frame(V_POS[v], V_D[v], V_EXP[v], V_MID[v]);

    // reset in the middle of a frame
    @(negedge clk);
    cmp_pos_i = 1'b1;
    cmp_neg_i = 1'b0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (20) @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk_idle("R1 mid-frame reset");
    chk("R1 result cleared", int'(result_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    prev_small = 0;
    repeat (2) @(negedge clk);
    chk_idle("R1 after mid-frame reset");
    run_frame(1, 3, 19, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule